// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block divides one fast source clock into two independently programmed output banks. Bank A fans out to two differential output pairs and bank B fans out to four. Each bank has its own 2-bit ratio select and its own output enable. A single active-high master reset clears both dividers at once. Every output comes as a true and complement pair. Within a bank, all pairs carry one divided clock.

Every ratio gives a 50% duty cycle, including the odd one. Divide-by-5 keeps equal 2.5-cycle high and low times by adding a half-period term clocked on the falling source edge. A change of ratio takes effect only at the end of a complete output period. The enable is re-timed into the low phase of the divided clock, so switching a bank off or on never cuts a pulse short.

Top module: `dual_bank_clkdiv`

## Requirements
- R1: Bank A divides the source clock by 4, 5, 8 or 16 for select codes 00, 01, 10 and 11 respectively (output period in source cycles).
- R2: Bank B divides the source clock by 2, 4, 5 or 8 for select codes 00, 01, 10 and 11 respectively.
- R3: For every ratio N the true output is high for exactly N half source periods and low for exactly N half source periods. For N = 5 this is 2.5 cycles each.
- R4: While the master reset is high, every true output is low and every complement output is high. After release, each true output first rises at the first source rising edge at which the reset is sampled low.
- R5: A select change is adopted only when the divider completes a full period. No output period is shortened or stretched by a select change.
- R6: Dropping a bank's enable lets any high phase in progress finish and holds the true outputs low from the next period on. Raising it again releases the outputs at the start of a full high phase.
- R7: All pairs within a bank carry identical true outputs, and each complement output is the inverse of its true output.
- R8: The select, the enable and the running state of one bank have no effect on the other bank's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Fast source clock feeding both dividers |
| masterRst | input | 1 | Active-high master reset for both banks |
| ratioSelA | input | 2 | Bank A ratio code |
| ratioSelB | input | 2 | Bank B ratio code |
| outEnA | input | 1 | Bank A output enable, active high |
| outEnB | input | 1 | Bank B output enable, active high |
| clkOutA | output | A_PAIRS | Bank A true outputs |
| clkOutAn | output | A_PAIRS | Bank A complement outputs |
| clkOutB | output | B_PAIRS | Bank B true outputs |
| clkOutBn | output | B_PAIRS | Bank B complement outputs |

## Verification
The assertions assume that the selects, the enables and the reset are quasi-static with respect to the source clock: they change well clear of both source edges and never within a setup window. They also assume the source clock keeps running while reset is asserted, because the reset is taken on the clock. The stimulus moves every input 2 ns after a rising source edge, well before the following falling edge, so both the rising-edge and falling-edge logic see clean values. A behavioural half-cycle model in the bench predicts each bank output after every source edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic {BANK_A, BANK_B} bankKind_e;

  // strobes from the counting control to the output datapath
  typedef struct packed {
    logic riseHalf;    // divided clock high for the coming full source cycle
    logic holdHalf;    // extend the high phase by half a cycle (odd ratios)
    logic parkWindow;  // last count of the period: output is low here
  } divStrobe_t;

  function automatic int ratioOf(bankKind_e kind, logic [1:0] sel);
    int r;
    if (kind == BANK_A) begin
      case (sel)
        2'b00:   r = 4;
        2'b01:   r = 5;
        2'b10:   r = 8;
        default: r = 16;
      endcase
    end else begin
      case (sel)
        2'b00:   r = 2;
        2'b01:   r = 4;
        2'b10:   r = 5;
        default: r = 8;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/bank_div_ctrl.sv
module bank_div_ctrl
  import clkdiv_pkg::*;
#(
  parameter bankKind_e KIND  = BANK_A,
  parameter int        DIV_W = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  output divStrobe_t strb
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] curDiv;
  logic [DIV_W-1:0] selDiv;
  logic [DIV_W-1:0] cntNext;
  logic [DIV_W-1:0] halfLo;
  logic [DIV_W-1:0] holdCnt;
  logic             atEnd;

  assign selDiv  = DIV_W'(ratioOf(KIND, sel));
  assign atEnd   = (cnt == curDiv - DIV_W'(1));
  assign cntNext = atEnd ? '0 : cnt + DIV_W'(1);
  assign halfLo  = curDiv >> 1;
  assign holdCnt = (curDiv - DIV_W'(3)) >> 1;

  // reset parks the counter on its terminal count so the first
  // released edge starts a fresh period with the current select
  always_ff @(posedge clk) begin
    if (rst) begin
      curDiv <= selDiv;
      cnt    <= selDiv - DIV_W'(1);
    end else begin
      cnt <= cntNext;
      if (atEnd) curDiv <= selDiv;
    end
  end

  always_comb begin
    strb.riseHalf   = atEnd | (cntNext < halfLo);
    strb.holdHalf   = curDiv[0] & (cnt == holdCnt);
    strb.parkWindow = atEnd;
  end

  // count never leaves the range of the active ratio (R1, R2)
  assert_cnt_in_range_R1: assert property (
    @(posedge clk) disable iff (rst) cnt < curDiv
  ) else $error("count out of range");

  // active ratio only moves on the wrap to zero (R5)
  assert_ratio_hold_R5: assert property (
    @(posedge clk) disable iff (rst)
      (!$past(rst) && cnt != '0) |-> $stable(curDiv)
  ) else $error("ratio changed mid-period");

endmodule

// File: rtl/bank_div_dpath.sv
module bank_div_dpath
  import clkdiv_pkg::*;
#(
  parameter int PAIRS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oe,
  input  divStrobe_t       strb,
  output logic [PAIRS-1:0] qTrue,
  output logic [PAIRS-1:0] qComp
);

  logic hiP;    // rising-edge half of the divided clock
  logic hiN;    // falling-edge extension for odd ratios
  logic gate;   // enable, re-timed into the low phase
  logic divClk;

  always_ff @(posedge clk) begin
    if (rst) hiP <= 1'b0;
    else     hiP <= strb.riseHalf;
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      hiN  <= 1'b0;
      gate <= oe;
    end else begin
      hiN <= strb.holdHalf;
      if (strb.parkWindow) gate <= oe;
    end
  end

  assign divClk = (hiP | hiN) & gate & ~rst;

  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    assign qTrue[i] = divClk;
    assign qComp[i] = ~divClk;
  end

  // the half-cycle extension always overlaps the main high phase (R3)
  assert_half_overlap_R3: assert property (
    @(posedge clk) disable iff (rst) hiN |-> hiP
  ) else $error("half-cycle term without main high phase");

  // enable gate never moves while the divided clock is high (R6)
  assert_gate_quiet_R6: assert property (
    @(negedge clk) disable iff (rst) hiP |=> $stable(gate)
  ) else $error("enable changed during high phase");

endmodule

// File: rtl/dual_bank_clkdiv.sv
module dual_bank_clkdiv
  import clkdiv_pkg::*;
#(
  parameter int A_PAIRS = 2,
  parameter int B_PAIRS = 4,
  parameter int MAX_DIV = 16
) (
  input  logic               srcClk,
  input  logic               masterRst,
  input  logic [1:0]         ratioSelA,
  input  logic [1:0]         ratioSelB,
  input  logic               outEnA,
  input  logic               outEnB,
  output logic [A_PAIRS-1:0] clkOutA,
  output logic [A_PAIRS-1:0] clkOutAn,
  output logic [B_PAIRS-1:0] clkOutB,
  output logic [B_PAIRS-1:0] clkOutBn
);

  localparam int DIV_W = $clog2(MAX_DIV + 1);

  divStrobe_t strbA;
  divStrobe_t strbB;

  bank_div_ctrl #(.KIND(BANK_A), .DIV_W(DIV_W)) i_ctrlA (
    .clk(srcClk), .rst(masterRst), .sel(ratioSelA), .strb(strbA)
  );

  bank_div_dpath #(.PAIRS(A_PAIRS)) i_dpathA (
    .clk(srcClk), .rst(masterRst), .oe(outEnA), .strb(strbA),
    .qTrue(clkOutA), .qComp(clkOutAn)
  );

  bank_div_ctrl #(.KIND(BANK_B), .DIV_W(DIV_W)) i_ctrlB (
    .clk(srcClk), .rst(masterRst), .sel(ratioSelB), .strb(strbB)
  );

  bank_div_dpath #(.PAIRS(B_PAIRS)) i_dpathB (
    .clk(srcClk), .rst(masterRst), .oe(outEnB), .strb(strbB),
    .qTrue(clkOutB), .qComp(clkOutBn)
  );

endmodule

// File: tb/test_dual_bank_clkdiv.sv
module test_dual_bank_clkdiv;

  logic       srcClk = 1'b0;
  logic       masterRst = 1'b1;
  logic [1:0] ratioSelA = 2'b00;
  logic [1:0] ratioSelB = 2'b10;
  logic       outEnA = 1'b1;
  logic       outEnB = 1'b1;
  logic [1:0] clkOutA, clkOutAn;
  logic [3:0] clkOutB, clkOutBn;

  dual_bank_clkdiv i_dual_bank_clkdiv (
    .srcClk(srcClk), .masterRst(masterRst),
    .ratioSelA(ratioSelA), .ratioSelB(ratioSelB),
    .outEnA(outEnA), .outEnB(outEnB),
    .clkOutA(clkOutA), .clkOutAn(clkOutAn),
    .clkOutB(clkOutB), .clkOutBn(clkOutBn)
  );

  always #10 srcClk = ~srcClk;   // 50 MHz

  int    checks = 0;
  int    failures = 0;
  string tagA = "R1";
  string tagB = "R2";
  event  smp;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic int divA(logic [1:0] s);
    return (s == 2'b00) ? 4 : (s == 2'b01) ? 5 : (s == 2'b10) ? 8 : 16;
  endfunction

  function automatic int divB(logic [1:0] s);
    return (s == 2'b00) ? 2 : (s == 2'b01) ? 4 : (s == 2'b10) ? 5 : 8;
  endfunction

  // behavioural model in half-cycle steps
  int h[2];
  int n[2];
  bit run[2];
  bit gm[2];

  task automatic stepBank(int b, bit rising, logic [1:0] s, bit oe);
    int nd;
    nd = (b == 0) ? divA(s) : divB(s);
    if (rising) begin
      if (masterRst) begin
        run[b] = 1'b0; n[b] = nd;
      end else if (!run[b]) begin
        run[b] = 1'b1; h[b] = 0; n[b] = nd;
      end else begin
        h[b]++;
        if (h[b] == 2 * n[b]) begin h[b] = 0; n[b] = nd; end
      end
    end else begin
      if (masterRst || !run[b]) gm[b] = oe;
      else begin
        h[b]++;
        if (h[b] == 2 * n[b] - 1) gm[b] = oe;
      end
    end
  endtask

  function automatic bit expOut(int b);
    return !masterRst && run[b] && gm[b] && (h[b] < n[b]);
  endfunction

  always @(srcClk) begin
    stepBank(0, srcClk, ratioSelA, outEnA);
    stepBank(1, srcClk, ratioSelB, outEnB);
    #5;
    chk(clkOutA == {2{expOut(0)}}, tagA, clkOutA, {2{expOut(0)}});
    chk(clkOutB == {4{expOut(1)}}, tagB, clkOutB, {4{expOut(1)}});
    // R7: pairs identical, complements inverse
    chk(clkOutAn == ~clkOutA && clkOutA == {2{clkOutA[0]}}, "R7", {clkOutAn, clkOutA}, {~clkOutA, clkOutA});
    chk(clkOutBn == ~clkOutB && clkOutB == {4{clkOutB[0]}}, "R7", {clkOutBn, clkOutB}, {~clkOutB, clkOutB});
    ->smp;
  end

  function automatic bit bitOf(int b);
    return (b == 0) ? clkOutA[0] : clkOutB[0];
  endfunction

  // high and low lengths in half periods (R1, R2, R3)
  task automatic measure(int b, int expN, string tag);
    bit p;
    int hi, lo;
    p = bitOf(b);
    forever begin @smp; if (bitOf(b) && !p) break; p = bitOf(b); end
    hi = 1;
    forever begin @smp; if (!bitOf(b)) break; hi++; end
    lo = 1;
    forever begin @smp; if (bitOf(b)) break; lo++; end
    chk(hi == expN, tag, hi, expN);
    chk(lo == expN, tag, lo, expN);
  endtask

  task automatic cyc(int k);
    repeat (k) @(posedge srcClk);
    #2;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge srcClk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    cyc(3);
    // R4: reset state
    #3;
    chk(clkOutA == 2'b00 && clkOutAn == 2'b11, "R4", {clkOutAn, clkOutA}, 4'b1100);
    chk(clkOutB == 4'h0 && clkOutBn == 4'hF, "R4", {clkOutBn, clkOutB}, 8'hF0);
    cyc(1);
    masterRst = 1'b0;
    #3;
    chk(clkOutA == 2'b00, "R4", clkOutA, 0);
    @(posedge srcClk); #5;
    chk(clkOutA == 2'b11 && clkOutB == 4'hF, "R4", {clkOutB, clkOutA}, 6'h3F);
    cyc(1);

    for (int s = 0; s < 4; s++) begin
      ratioSelA = 2'(s);
      ratioSelB = 2'(s);
      cyc(40);
      measure(0, divA(2'(s)), "R1 R3");
      measure(1, divB(2'(s)), "R2 R3");
    end

    // R5: select change mid-period, bank B untouched (R8)
    tagA = "R5"; tagB = "R8";
    ratioSelA = 2'b11; ratioSelB = 2'b10;
    cyc(23);
    ratioSelA = 2'b01;
    cyc(7);
    ratioSelA = 2'b10;
    cyc(3);
    ratioSelA = 2'b00;
    cyc(40);
    measure(0, 4, "R5");

    // R6: enable off and on, bank B unaffected (R8)
    tagA = "R6";
    ratioSelA = 2'b10;
    cyc(21);
    outEnA = 1'b0;
    cyc(30);
    chk(clkOutA == 2'b00, "R6", clkOutA, 0);
    measure(1, 5, "R8");
    outEnA = 1'b1;
    cyc(5);
    outEnA = 1'b0;
    cyc(3);
    outEnA = 1'b1;
    cyc(30);
    measure(0, 8, "R6");

    // R8: bank B enable off, bank A keeps running
    tagA = "R8"; tagB = "R6";
    outEnB = 1'b0;
    cyc(20);
    measure(0, 8, "R8");
    outEnB = 1'b1;
    cyc(20);

    // R4: reset in the middle of a run
    tagA = "R4"; tagB = "R4";
    ratioSelB = 2'b01;
    cyc(9);
    masterRst = 1'b1;
    #3;
    chk(clkOutA == 2'b00 && clkOutBn == 4'hF, "R4", {clkOutBn, clkOutA}, 6'h3C);
    cyc(4);
    masterRst = 1'b0;
    cyc(40);
    measure(1, 4, "R4");
    summary();
  end

endmodule